// File: doc/BRIEF.md
# Pseudo-random line self-test engine

This block lets a line transceiver test its own datapath. With the test enable low, the transmit pair passes straight through from the user inputs to the line outputs. With the test enable high, the block replaces the transmit data with a pseudo-random stream. This stream comes from a 20-stage shift register, and a zero-run limiter stops it from holding the line at zero for long. The negative transmit output is held at zero during the test.

The same bits travel back through the external path (coders, equaliser, jitter attenuator) and reach the receive bit input. A checker loads its own shift register from those incoming bits until it can predict them. After a clean run it declares lock and then runs freely, counting mismatches in fixed windows. On lock, three status flags rise together and an active-low interrupt request is latched. Losing lock clears the flags and latches the interrupt again. A one-cycle acknowledge clears the interrupt request.

Top module: `qrss_bist`

## Requirements
- R1: While `bist_en` is 0, `tx_pos_out` equals `tx_pos_in` and `tx_neg_out` equals `tx_neg_in` in the same cycle.
- R2: While `bist_en` is 1, `tx_neg_out` is 0 and the transmit inputs have no effect. `tx_pos_out` carries the generator bit. The raw bit is state[19] XOR state[16] (polynomial x^20 + x^17 + 1). Each clock the state shifts up by one with the raw bit entering bit 0. The state restarts at 20'h00001.
- R3: The transmitted generator bit is forced to 1 when the 14 raw bits before it were all 0. In every other case it equals the raw bit.
- R4: While searching, the checker shifts each received bit into its own state. A received bit counts as a hit when the state is non-zero and the bit equals the state's predicted raw bit. The 32nd consecutive hit sets lock.
- R5: On the clock edge after lock is set, `tx_pattern_flag`, `perf_pattern_flag` and `selftest_flag` all become 1 and `irq_n` goes to 0.
- R6: While locked, the checker predicts each bit (raw plus zero-run forcing) from its free-running state and counts mismatches in consecutive fixed 64-bit windows that start at lock. A 4th mismatch inside one window drops lock, and fewer mismatches keep it. One edge after the drop the three flags clear and `irq_n` goes to 0.
- R7: A 1 on `irq_ack` returns `irq_n` to 1 on the next edge, unless lock changes state in that cycle.
- R8: While `bist_en` is 0, the generator is held at its start state, the checker is held in search with a zero state, and the flags and interrupt are 0 and inactive from the next edge on.
- R9: After synchronous reset (`rst_n` low at an edge), all flags are 0 and `irq_n` is 1.
- R10: A receive input held at 0 never produces lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bist_en | input | 1 | Self-test enable |
| tx_pos_in | input | 1 | User positive transmit data |
| tx_neg_in | input | 1 | User negative transmit data |
| rx_bit | input | 1 | Received bit from the looped-back path |
| irq_ack | input | 1 | Clears the latched interrupt request |
| tx_pos_out | output | 1 | Positive transmit data to the line |
| tx_neg_out | output | 1 | Negative transmit data to the line |
| tx_pattern_flag | output | 1 | Transmit-side pattern-lock flag |
| perf_pattern_flag | output | 1 | Performance-side pattern-lock flag |
| selftest_flag | output | 1 | Self-test pass flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `bist_en`, `irq_ack` and `rx_bit` change only between clock edges and that the receive input delivers exactly one bit on every clock. They also assume that reset is held for at least one edge before any check matters. The bench changes every input on the falling edge. It feeds the receive input from a three-cycle delay line of its own model of the transmitted stream, and it can invert chosen bits or hold the input at zero. This keeps the loopback free of gaps, as the checker expects.

// File: rtl/qrss_pkg.sv
// Shared constants and types for the pseudo-random self-test engine.
// Assumes one line bit per clock; all counts below are defaults for the modules.
package qrss_pkg;
    localparam int unsigned LFSR_W     = 20;   // generator/checker register length
    localparam int unsigned LFSR_TAP   = 17;   // second feedback tap (x^17)
    localparam int unsigned ZRUN_LIMIT = 14;   // raw zeros before a forced one
    localparam int unsigned LOCK_RUN   = 32;   // consecutive hits needed for lock
    localparam int unsigned LOSS_ERRS  = 4;    // mismatches per window that drop lock
    localparam int unsigned WIN_LEN    = 64;   // mismatch window length in bits
    localparam int unsigned NUM_FLAGS  = 3;    // status flags raised on lock
    localparam logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(1);

    typedef enum logic {
        CHK_SEARCH = 1'b0,
        CHK_LOCKED = 1'b1
    } chk_mode_e;
endpackage

// File: rtl/qrss_gen.sv
// Pattern source: Fibonacci shift register with zero-run forcing.
// Assumes run is synchronous; while run is low the register sits at its seed.
module qrss_gen #(
    parameter int unsigned W    = qrss_pkg::LFSR_W,
    parameter int unsigned TAP  = qrss_pkg::LFSR_TAP,
    parameter int unsigned ZLIM = qrss_pkg::ZRUN_LIMIT,
    parameter logic [W-1:0] SEED = qrss_pkg::LFSR_SEED
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic gen_bit
);
    localparam int unsigned ZW = $clog2(ZLIM + 1);
    localparam logic [ZW-1:0] ZMAX = ZW'(ZLIM);

    logic [W-1:0]  sr;
    logic [ZW-1:0] zrun;
    logic          raw;

    // raw feedback and forced-one output
    always_comb begin
        raw     = sr[W-1] ^ sr[TAP-1];
        gen_bit = raw | (zrun == ZMAX);
    end

    // advance the register and the raw zero-run count
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sr   <= SEED;
            zrun <= '0;
        end else begin
            sr   <= {sr[W-2:0], raw};
            zrun <= raw ? '0 : ((zrun == ZMAX) ? zrun : zrun + 1'b1);
        end
    end

    // R2: the source register never collapses to all zeros
    p_state_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (sr != '0));
endmodule

// File: rtl/qrss_chk.sv
// Self-synchronising pattern checker with lock and loss detection.
// Assumes one received bit per clock while run is high; run low holds it in search.
module qrss_chk
    import qrss_pkg::*;
#(
    parameter int unsigned W         = LFSR_W,
    parameter int unsigned TAP       = LFSR_TAP,
    parameter int unsigned ZLIM      = ZRUN_LIMIT,
    parameter int unsigned RUN_NEED  = LOCK_RUN,
    parameter int unsigned ERR_LIMIT = LOSS_ERRS,
    parameter int unsigned WIN       = WIN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rx_bit,
    output logic locked
);
    localparam int unsigned ZW  = $clog2(ZLIM + 1);
    localparam int unsigned RW  = $clog2(RUN_NEED + 1);
    localparam int unsigned EW  = $clog2(ERR_LIMIT + 1);
    localparam int unsigned WW  = $clog2(WIN);
    localparam logic [ZW-1:0] ZMAX     = ZW'(ZLIM);
    localparam logic [RW-1:0] RUN_LAST = RW'(RUN_NEED - 1);
    localparam logic [EW-1:0] ERR_LAST = EW'(ERR_LIMIT - 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN - 1);

    chk_mode_e     mode;
    logic [W-1:0]  sr;
    logic [ZW-1:0] zrun;
    logic [RW-1:0] hits;
    logic [EW-1:0] errs;
    logic [WW-1:0] wpos;
    logic          pred_raw, pred_bit, search_hit, bit_err;

    // prediction and comparison against the received bit
    always_comb begin
        pred_raw   = sr[W-1] ^ sr[TAP-1];
        pred_bit   = pred_raw | (zrun == ZMAX);
        search_hit = (rx_bit == pred_raw) && (sr != '0);
        bit_err    = (rx_bit != pred_bit);
    end

    assign locked = (mode == CHK_LOCKED);

    // search/lock state machine with run and window counters
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            mode <= CHK_SEARCH;
            sr   <= '0;
            zrun <= '0;
            hits <= '0;
            errs <= '0;
            wpos <= '0;
        end else if (mode == CHK_SEARCH) begin
            sr   <= {sr[W-2:0], rx_bit};
            zrun <= rx_bit ? '0 : ((zrun == ZMAX) ? zrun : zrun + 1'b1);
            errs <= '0;
            wpos <= '0;
            if (!search_hit) begin
                hits <= '0;
            end else if (hits == RUN_LAST) begin
                hits <= '0;
                mode <= CHK_LOCKED;
            end else begin
                hits <= hits + 1'b1;
            end
        end else begin
            sr   <= {sr[W-2:0], pred_raw};
            zrun <= pred_raw ? '0 : ((zrun == ZMAX) ? zrun : zrun + 1'b1);
            if (bit_err && errs == ERR_LAST) begin
                mode <= CHK_SEARCH;
                errs <= '0;
                wpos <= '0;
            end else if (wpos == WIN_LAST) begin
                wpos <= '0;
                errs <= '0;
            end else begin
                wpos <= wpos + 1'b1;
                errs <= errs + EW'(bit_err);
            end
        end
    end

    // R4: lock is entered only on the final hit of a full run
    p_lock_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(hits) == RUN_LAST && $past(search_hit)));

    // R6: the window error count stays below the loss limit while locked
    p_err_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (errs < EW'(ERR_LIMIT)));

    // R10: an all-zero register never advances the hit count
    p_zero_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !locked && sr == '0) |=> (hits == '0));
endmodule

// File: rtl/qrss_status.sv
// Lock flags and latched interrupt request.
// Assumes locked comes from the checker; a lock change sets the request, ack clears it.
module qrss_status #(
    parameter int unsigned NFLAGS = qrss_pkg::NUM_FLAGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              locked,
    input  logic              irq_ack,
    output logic [NFLAGS-1:0] flags,
    output logic              irq_n
);
    logic irq_pend;
    logic lock_change;

    // one registered copy of the lock state per flag
    for (genvar gi = 0; gi < NFLAGS; gi++) begin : g_flag
        logic flag_q;
        // follow lock while the test runs
        always_ff @(posedge clk) begin
            if (!rst_n || !run) flag_q <= 1'b0;
            else                flag_q <= locked;
        end
        assign flags[gi] = flag_q;
    end

    assign lock_change = run && (locked != flags[0]);

    // latch the request on any lock change, clear on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   irq_pend <= 1'b0;
        else if (lock_change) irq_pend <= 1'b1;
        else if (irq_ack)     irq_pend <= 1'b0;
    end

    assign irq_n = !irq_pend;

    // R5: gaining lock raises every flag and the request
    p_lock_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && locked && !flags[0]) |=> (&flags && !irq_n));

    // R6: losing lock clears every flag and raises the request
    p_drop_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !locked && flags[0]) |=> (flags == '0 && !irq_n));

    // R7: acknowledge without a lock change releases the request
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && irq_ack && (locked == flags[0])) |=> irq_n);

    // R8: leaving test mode clears flags and request
    p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (flags == '0 && irq_n));
endmodule

// File: rtl/qrss_bist.sv
// Self-test top: selects line transmit data and ties generator, checker and status.
// Assumes the line path returns the transmitted bits on rx_bit, one per clock.
module qrss_bist (
    input  logic clk,
    input  logic rst_n,
    input  logic bist_en,
    input  logic tx_pos_in,
    input  logic tx_neg_in,
    input  logic rx_bit,
    input  logic irq_ack,
    output logic tx_pos_out,
    output logic tx_neg_out,
    output logic tx_pattern_flag,
    output logic perf_pattern_flag,
    output logic selftest_flag,
    output logic irq_n
);
    import qrss_pkg::*;

    logic                 gen_bit;
    logic                 chk_locked;
    logic [NUM_FLAGS-1:0] flag_vec;

    qrss_gen u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (bist_en),
        .gen_bit(gen_bit)
    );

    qrss_chk u_chk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (bist_en),
        .rx_bit(rx_bit),
        .locked(chk_locked)
    );

    qrss_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (bist_en),
        .locked (chk_locked),
        .irq_ack(irq_ack),
        .flags  (flag_vec),
        .irq_n  (irq_n)
    );

    // transmit select: generator during test, user pair otherwise
    always_comb begin
        tx_pos_out = bist_en ? gen_bit : tx_pos_in;
        tx_neg_out = bist_en ? 1'b0    : tx_neg_in;
    end

    assign tx_pattern_flag   = flag_vec[0];
    assign perf_pattern_flag = flag_vec[1];
    assign selftest_flag     = flag_vec[2];
endmodule

// File: tb/test_qrss_bist.sv
// Bench: behavioural model of generator, checker and status, compared every cycle.
module test_qrss_bist;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bist_en = 1'b0, tx_pos_in = 1'b0, tx_neg_in = 1'b0;
    logic rx_bit = 1'b0, irq_ack = 1'b0;
    logic tx_pos_out, tx_neg_out, tx_pattern_flag, perf_pattern_flag, selftest_flag, irq_n;

    int n_chk = 0;
    int n_err = 0;
    int n_cyc = 0;
    bit done  = 0;

    // stimulus controls
    bit inj = 0;
    bit rx_zero = 0;
    bit lb_q[$] = '{0, 0, 0};

    // model state
    int m_g = 1, m_gz = 0;
    int m_c = 0, m_cz = 0, m_good = 0, m_errs = 0, m_win = 0;
    bit m_locked = 0, m_flag = 0, m_irq = 0;

    always #5 clk = ~clk;

    qrss_bist i_qrss_bist (
        .clk(clk), .rst_n(rst_n), .bist_en(bist_en),
        .tx_pos_in(tx_pos_in), .tx_neg_in(tx_neg_in), .rx_bit(rx_bit), .irq_ack(irq_ack),
        .tx_pos_out(tx_pos_out), .tx_neg_out(tx_neg_out),
        .tx_pattern_flag(tx_pattern_flag), .perf_pattern_flag(perf_pattern_flag),
        .selftest_flag(selftest_flag), .irq_n(irq_n)
    );

    function automatic int raw_of(int s);
        return ((s >> 19) ^ (s >> 16)) & 1;
    endfunction

    function automatic int out_of(int s, int z);
        return (raw_of(s) != 0 || z >= 14) ? 1 : 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        int raw, pred, expb, e, cur;
        n_cyc++;
        cur = bist_en ? out_of(m_g, m_gz) : int'(tx_pos_in);
        lb_q.push_back(cur[0]);
        void'(lb_q.pop_front());
        if (!rst_n) begin
            m_g = 1; m_gz = 0; m_c = 0; m_cz = 0; m_good = 0; m_errs = 0; m_win = 0;
            m_locked = 0; m_flag = 0; m_irq = 0;
        end else if (!bist_en) begin
            m_g = 1; m_gz = 0; m_c = 0; m_cz = 0; m_good = 0; m_errs = 0; m_win = 0;
            m_locked = 0; m_flag = 0; m_irq = 0;
        end else begin
            if (m_locked != m_flag) m_irq = 1;
            else if (irq_ack)       m_irq = 0;
            m_flag = m_locked;
            pred = raw_of(m_c);
            if (!m_locked) begin
                if (int'(rx_bit) == pred && m_c != 0) begin
                    if (m_good == 31) begin m_locked = 1; m_good = 0; end
                    else m_good++;
                end else m_good = 0;
                m_c  = ((m_c << 1) | int'(rx_bit)) & 32'hFFFFF;
                m_cz = rx_bit ? 0 : ((m_cz < 14) ? m_cz + 1 : 14);
                m_win = 0; m_errs = 0;
            end else begin
                expb = (pred != 0 || m_cz >= 14) ? 1 : 0;
                e = (int'(rx_bit) != expb) ? 1 : 0;
                m_c  = ((m_c << 1) | pred) & 32'hFFFFF;
                m_cz = (pred != 0) ? 0 : ((m_cz < 14) ? m_cz + 1 : 14);
                if (e != 0 && m_errs == 3) begin m_locked = 0; m_errs = 0; m_win = 0; end
                else if (m_win == 63) begin m_win = 0; m_errs = 0; end
                else begin m_win++; m_errs += e; end
            end
            raw  = raw_of(m_g);
            m_g  = ((m_g << 1) | raw) & 32'hFFFFF;
            m_gz = (raw != 0) ? 0 : ((m_gz < 14) ? m_gz + 1 : 14);
        end
        if (n_cyc > 100000 && !done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual %0d expected %0d", n_cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    // one cycle: drive at the falling edge, then compare all outputs to the model
    task automatic cyc(bit b, bit ack, bit err_in);
        @(negedge clk);
        bist_en   = b;
        irq_ack   = ack;
        inj       = err_in;
        tx_pos_in = 1'($urandom);
        tx_neg_in = 1'($urandom);
        rx_bit    = rx_zero ? 1'b0 : (lb_q[0] ^ inj);
        #1;
        check(b ? "R2/R3 tx_pos" : "R1 tx_pos", int'(tx_pos_out),
              b ? out_of(m_g, m_gz) : int'(tx_pos_in));
        check(b ? "R2 tx_neg" : "R1 tx_neg", int'(tx_neg_out), b ? 0 : int'(tx_neg_in));
        check("R4/R5/R6 tx_pattern_flag", int'(tx_pattern_flag), int'(m_flag));
        check("R5 perf_pattern_flag", int'(perf_pattern_flag), int'(m_flag));
        check("R5 selftest_flag", int'(selftest_flag), int'(m_flag));
        check("R5/R6/R7 irq_n", int'(irq_n), int'(!m_irq));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9 reset flags", int'({tx_pattern_flag, perf_pattern_flag, selftest_flag}), 0);
        check("R9 reset irq_n", int'(irq_n), 1);

        // R1: pass-through with self-test off
        for (int i = 0; i < 20; i++) cyc(0, 0, 0);

        // R2 R3 R4: run the loopback until lock
        for (int i = 0; i < 400; i++) cyc(1, 0, 0);
        check("R4 lock reached", int'(selftest_flag), 1);
        check("R5 irq_n low on lock", int'(irq_n), 0);

        // R7: acknowledge releases the request
        cyc(1, 1, 0);
        cyc(1, 0, 0);
        check("R7 irq_n after ack", int'(irq_n), 1);

        // R6: three errors keep lock
        for (int k = 0; k < 3; k++) begin
            cyc(1, 0, 1);
            for (int i = 0; i < 9; i++) cyc(1, 0, 0);
        end
        check("R6 lock kept with three errors", int'(tx_pattern_flag), 1);
        check("R6 no request with three errors", int'(irq_n), 1);
        for (int i = 0; i < 70; i++) cyc(1, 0, 0);

        // R6: a burst of errors drops lock
        for (int k = 0; k < 8; k++) begin
            cyc(1, 0, 1);
            cyc(1, 0, 0);
        end
        cyc(1, 0, 0);
        check("R6 lock dropped", int'(perf_pattern_flag), 0);
        check("R6 irq_n low on loss", int'(irq_n), 0);

        // R4: relock after clean bits return
        cyc(1, 1, 0);
        for (int i = 0; i < 300; i++) cyc(1, 0, 0);
        check("R4 relock", int'(selftest_flag), 1);

        // R8: leaving test mode clears everything
        cyc(0, 0, 0);
        cyc(0, 0, 0);
        check("R8 flags cleared", int'({tx_pattern_flag, perf_pattern_flag, selftest_flag}), 0);
        check("R8 irq_n released", int'(irq_n), 1);

        // R10: a stuck-zero receive input never locks
        rx_zero = 1;
        for (int i = 0; i < 150; i++) cyc(1, 0, 0);
        check("R10 no lock on zeros", int'(selftest_flag), 0);
        check("R10 no request on zeros", int'(irq_n), 1);
        rx_zero = 0;

        // R8: restart from the seed and lock again
        for (int i = 0; i < 5; i++) cyc(0, 0, 0);
        for (int i = 0; i < 300; i++) cyc(1, 0, 0);
        check("R8 lock after restart", int'(tx_pattern_flag), 1);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule